// File: doc/BRIEF.md
# Serial Register and Result Port

This block is the host-facing serial slave of a data-acquisition front end. A host frames each transaction with an active-low chip select and clocks bits in most significant bit first. The first two bits name the operation: a register write, a register read, or a read of one buffered conversion result. The block turns these frames into single-cycle write strobes with address and data for a configuration register bank that lives elsewhere, fetches read data from that bank, and streams tagged result words out of a result source. It holds no register contents of its own.

All serial inputs are brought into the system clock domain through synchronizer chains, and all frame logic runs on `clk`. The serial clock must therefore be slow against `clk`: each high and low phase of the serial clock lasts at least four `clk` cycles, and chip select falls at least four `clk` cycles before the first serial-clock rise. Bits are sampled on serial-clock rising edges and the serial output changes after falling edges.

The result side is a valid/ready stream. The source keeps `res_valid` high and `res_data` stable until it sees `res_ready`, which is a one-cycle pop. The port never applies back-pressure in any other way: if the host never asks for a result, `res_ready` simply stays low and the source waits.

Top module: `spi_regport`

## Requirements
- R1: While chip select is high, `spi_sdo` is low, and after reset `cfg_wr` and `res_ready` are low.
- R2: The first two bits of a frame, first bit as the upper one, select the operation: 2'b10 register write, 2'b01 register read, 2'b00 result read; 2'b11 has no effect (no strobe, no pop, `spi_sdo` low).
- R3: In a write frame of 16 bits, bits 13:10 (bit 15 being the first sent) carry the address and bits 7:0 the data; when chip select rises after at least 16 bits, `cfg_wr` pulses for one cycle with `cfg_addr` and `cfg_wdata` holding them.
- R4: A write frame cut off by chip select before its 16th bit produces no strobe and leaves the register bank unchanged.
- R5: Writes to the read-only status address STATUS_ADDR (default 0xA) or to any address above LAST_ADDR (default 0xA) produce no strobe.
- R6: In a read frame the address sits in bits 13:10; `spi_sdo` is low for the first eight bit periods and carries the register's eight data bits, upper bit first, in bit periods 9 to 16.
- R7: A read of any address above LAST_ADDR returns zero whatever the bank presents.
- R8: In a result frame, bit periods 3 to 22 carry the 20-bit result word, upper bit first.
- R9: When chip select rises after the host has clocked at least one result bit, `res_ready` pulses once, so the next result frame presents the next word, also when the frame was cut short (for example after the 12-bit code).
- R10: A result frame ended before its first result bit pops nothing, and the next frame presents the same word again.
- R11: A result frame started while `res_valid` is low shifts out zeros and pops nothing; `res_ready` is only ever high together with `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Active-low chip select from the host |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host |
| cfg_addr | output | 4 | Register address of the current frame |
| cfg_wdata | output | 8 | Register write data |
| cfg_wr | output | 1 | One-cycle register write strobe |
| cfg_rdata | input | 8 | Register contents at `cfg_addr` |
| res_data | input | 20 | Result word at the head of the result buffer |
| res_valid | input | 1 | Result word available |
| res_ready | output | 1 | One-cycle result pop |

## Verification
The bench builds the port with its defaults: a two-stage synchronizer, a 4-bit address with LAST_ADDR and STATUS_ADDR both at 0xA, 8-bit data and 20-bit results, and drives the serial clock at eight system clocks per phase. The register bank behind the port is modelled with nonzero contents at every address, so a zero read above 0xA and an unchanged status register are both visible at the pins. With a four-word result source, full, truncated, aborted and empty result frames reach every pop rule, including the one where the source runs dry.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  // Operation code carried by the first two bits of a frame
  typedef enum logic [1:0] {
    OP_RES = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_NOP = 2'b11
  } spi_op_e;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
#(
  parameter int              ADDR_W      = 4,
  parameter int              DATA_W      = 8,
  parameter int              RES_W       = 20,
  parameter logic [ADDR_W-1:0] LAST_ADDR   = 4'hA,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              sclk_fall,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wdata,
  output logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic [RES_W-1:0]  res_data,
  input  logic              res_valid,
  output logic              res_ready,
  output logic              tx_load,
  output logic [RES_W-1:0]  tx_value
);

  localparam int FRAME_W  = 2 + ADDR_W + 2 + DATA_W;
  localparam int MAX_BITS = (FRAME_W > RES_W + 2) ? FRAME_W : RES_W + 2;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_OP    = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ADDR  = CNT_W'(1 + ADDR_W);
  localparam logic [CNT_W-1:0] CNT_RDLD  = CNT_W'(FRAME_W - DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_RES1  = CNT_W'(3);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  logic             sclk_q, cs_q;
  logic             sclk_rise, cs_start, cs_end;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] rx;
  spi_op_e          op, op_next;
  logic             grab;
  logic             wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_act;
    end
  end

  assign sclk_rise = cs_act & sclk_s & ~sclk_q;
  assign sclk_fall = cs_act & ~sclk_s & sclk_q;
  assign cs_start  = cs_act & ~cs_q;
  assign cs_end    = ~cs_act & cs_q;
  assign op_next   = spi_op_e'({rx[0], sdi_s});
  assign wr_ok     = (cfg_addr <= LAST_ADDR) && (cfg_addr != STATUS_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rx        <= '0;
      op        <= OP_NOP;
      grab      <= 1'b0;
      cfg_addr  <= '0;
      cfg_wr    <= 1'b0;
      res_ready <= 1'b0;
    end else begin
      cfg_wr    <= 1'b0;
      res_ready <= 1'b0;
      if (cs_start) begin
        cnt  <= '0;
        rx   <= '0;
        op   <= OP_NOP;
        grab <= 1'b0;
      end else if (sclk_rise) begin
        if (cnt < CNT_FULL) rx <= {rx[DATA_W-2:0], sdi_s};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cnt == CNT_OP) begin
          op <= op_next;
          if (op_next == OP_RES) grab <= res_valid;
        end
        if (cnt == CNT_ADDR) cfg_addr <= {rx[ADDR_W-2:0], sdi_s};
      end else if (cs_end) begin
        cfg_wr    <= (op == OP_WR) && (cnt >= CNT_FULL) && wr_ok;
        res_ready <= (op == OP_RES) && grab && (cnt >= CNT_RES1);
        op        <= OP_NOP;
      end
    end
  end

  assign cfg_wdata = rx;

  // Load the output shifter: result word after the command bits, register
  // data after the address and pad bits of a read frame.
  always_comb begin
    tx_load  = 1'b0;
    tx_value = '0;
    if (sclk_rise && cnt == CNT_OP && op_next == OP_RES) begin
      tx_load  = 1'b1;
      tx_value = res_valid ? res_data : '0;
    end else if (sclk_rise && cnt == CNT_RDLD && op == OP_RD) begin
      tx_load  = 1'b1;
      tx_value = {(cfg_addr > LAST_ADDR) ? {DATA_W{1'b0}} : cfg_rdata,
                  {(RES_W-DATA_W){1'b0}}};
    end
  end

  // R11
  pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> res_valid);
  // R5
  wr_legal_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> (cfg_addr <= LAST_ADDR && cfg_addr != STATUS_ADDR));
  // R3
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !cfg_wr);
  // R9
  pop_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |=> !res_ready);
  // R2
  wr_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && res_ready));
  // R3
  wr_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> !cs_act);

endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx #(
  parameter int RES_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sclk_fall,
  input  logic             load,
  input  logic [RES_W-1:0] value,
  output logic             sdo
);

  logic [RES_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else if (!cs_act) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else if (load) begin
      sh <= value;
    end else if (sclk_fall) begin
      sdo <= sh[RES_W-1];
      sh  <= {sh[RES_W-2:0], 1'b0};
    end
  end

  // R1
  sdo_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo);
  // R6
  load_fall_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && sclk_fall));
  // R8
  sdo_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act) && !$stable(sdo)) |-> $past(sclk_fall));

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 8,
  parameter int                RES_W       = 20,
  parameter logic [ADDR_W-1:0] LAST_ADDR   = 4'hA,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wdata,
  output logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic [RES_W-1:0]  res_data,
  input  logic              res_valid,
  output logic              res_ready
);

  logic [2:0]       sync_out;
  logic             cs_act, sclk_s, sdi_s;
  logic             sclk_fall, tx_load;
  logic [RES_W-1:0] tx_value;

  spi_regport_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({spi_csn, spi_sclk, spi_sdi}),
    .dout  (sync_out)
  );

  assign cs_act = ~sync_out[2];
  assign sclk_s = sync_out[1];
  assign sdi_s  = sync_out[0];

  spi_regport_frame #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .RES_W       (RES_W),
    .LAST_ADDR   (LAST_ADDR),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_s    (sclk_s),
    .sdi_s     (sdi_s),
    .sclk_fall (sclk_fall),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata),
    .res_data  (res_data),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .tx_load   (tx_load),
    .tx_value  (tx_value)
  );

  spi_regport_tx #(
    .RES_W (RES_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_fall (sclk_fall),
    .load      (tx_load),
    .value     (tx_value),
    .sdo       (spi_sdo)
  );

endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_csn = 1'b1, spi_sclk = 1'b0, spi_sdi = 1'b0;
  logic        spi_sdo;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        cfg_wr;
  logic [7:0]  cfg_rdata;
  logic [19:0] res_data;
  logic        res_valid;
  logic        res_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  bank [16];
  logic [19:0] results [4];
  int          res_idx = 0;
  int          res_cnt = 4;
  logic [13:0] expq [$];   // {kind[1:0], addr[3:0], data[7:0]}; kind 1 write, 2 pop

  always #10 clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
    .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready)
  );

  assign cfg_rdata = bank[cfg_addr];
  assign res_valid = res_idx < res_cnt;
  assign res_data  = (res_idx < 4) ? results[res_idx] : 20'h0;

  always @(posedge clk) begin
    if (cfg_wr) bank[cfg_addr] <= cfg_wdata;
    if (res_ready) res_idx <= res_idx + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare every strobe against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && (cfg_wr || res_ready)) begin
      logic [13:0] got, exp;
      got = cfg_wr ? {2'd1, cfg_addr, cfg_wdata} : {2'd2, 12'h0};
      if (expq.size() == 0) exp = 14'h0;
      else exp = expq.pop_front();
      check("R3/R9 strobe", {18'h0, got}, {18'h0, exp});
    end
  end

  task automatic frame(input logic [31:0] bits, input int n, output logic [31:0] got);
    got = '0;
    @(negedge clk) spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      spi_sdi = bits[i];
      repeat (HALF) @(negedge clk);
      got = {got[30:0], spi_sdo};
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    spi_sdi = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit expect_strobe);
    logic [31:0] g;
    if (expect_strobe) expq.push_back({2'd1, a, d});
    frame({16'h0, 2'b10, a, 2'b00, d}, 16, g);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    logic [31:0] g;
    frame({16'h0, 2'b01, a, 10'h0}, 16, g);
    check(req, {24'h0, g[7:0]}, {24'h0, exp});
    check("R6 lead bits low", {24'h0, g[15:8]}, 32'h0);
  endtask

  task automatic res(input int nres, input logic [19:0] exp, input bit pop, input string req);
    logic [31:0] g;
    if (pop) expq.push_back({2'd2, 12'h0});
    frame(32'h0, 2 + nres, g);
    if (nres > 0)
      check(req, g & ((32'h1 << nres) - 1), {12'h0, exp} >> (20 - nres));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    for (int i = 0; i < 16; i++) bank[i] = 8'h40 + 8'(i) * 8'h11;
    results[0] = 20'hABCDE; results[1] = 20'h5A3C1;
    results[2] = 20'h12345; results[3] = 20'hF0F0F;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 sdo", {31'h0, spi_sdo}, 32'h0);
    check("R1 wr", {31'h0, cfg_wr}, 32'h0);
    check("R1 pop", {31'h0, res_ready}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3: writes then read back (R6)
    wr(4'h3, 8'hA5, 1'b1);
    rd(4'h3, 8'hA5, "R3 R6 readback 3");
    wr(4'h0, 8'h3C, 1'b1);
    rd(4'h0, 8'h3C, "R3 R6 readback 0");
    // R5: status address and out-of-range writes ignored
    wr(4'hA, 8'hFF, 1'b0);
    rd(4'hA, bank[10], "R5 status unchanged");
    check("R5 status value", {24'h0, bank[10]}, 32'h4A + 32'h11 * 10 - 32'hA);
    wr(4'hC, 8'h00, 1'b0);
    // R4: partial write frame dropped
    frame({22'h0, 2'b10, 4'h5, 2'b00, 2'b11}, 10, g);
    rd(4'h5, 8'h95, "R4 partial write dropped");
    // R7: out-of-range read is zero
    rd(4'hC, 8'h00, "R7 read above last");
    rd(4'hF, 8'h00, "R7 read top");
    // R2: opcode 11 has no effect
    frame({16'h0, 16'hC2FF}, 16, g);
    check("R2 nop sdo", g, 32'h0);
    rd(4'h0, 8'h3C, "R2 nop no write");

    // R8: full result
    res(20, results[0], 1'b1, "R8 full result");
    // R9: truncated after 12 bits, still pops
    res(12, results[1], 1'b1, "R9 truncated result");
    // R10: aborted before first result bit: no pop, same word next
    res(0, 20'h0, 1'b0, "R10");
    check("R10 index held", res_idx, 2);
    res(20, results[2], 1'b1, "R10 same word after abort");
    res(20, results[3], 1'b1, "R9 next word");
    // R11: source empty
    res(20, 20'h0, 1'b0, "R11 empty zeros");
    check("R11 no pop", res_idx, 4);

    check("R1 sdo idle", {31'h0, spi_sdo}, 32'h0);
    check("R3 queue drained", expq.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule